// File: doc/BRIEF.md
# Relay Leg Controller with Stall Abort

This block sequences one decode as a relay of attempts, called legs, over an iterative belief-propagation core. The core keeps its belief state between legs. The controller only signals a leg boundary so that a weight source can redraw the per-bit memory weights. Only the first boundary of a decode also tells the core to initialise its beliefs.

While a leg runs, the core returns one result per iteration. Each result carries the number of checks still failing, a flag that says all checks are satisfied, an error-estimate weight and the candidate error vector. The controller keeps the lowest-weight valid candidate across legs. It tracks the lowest failing-check count seen in the current leg. A leg ends for one of three reasons: that count has not improved for a programmable number of iterations, the leg reaches its iteration cap, or the leg produces a valid candidate.

The decode stops when the requested number of valid candidates has been collected, or when the leg budget is spent. It reports a one-cycle done pulse together with the outcome, the legs used and the total iteration count.

Top module: `relay_leg_ctrl`

## Requirements
- R1: After reset, `done_o`, `run_o`, `weights_req_o` and `core_init_o` are low, and `legs_used_o`, `iters_total_o` and `success_o` are zero.
- R2: Every leg opens with exactly one cycle of `weights_req_o` high while `run_o` is low, and `run_o` is high from the next cycle. `core_init_o` is high only with the first request of a decode, so later legs continue from the core's current beliefs.
- R3: `iters_total_o` counts the cycles in which `iter_valid_i` and `run_o` are both high. Cycles of a running leg with `iter_valid_i` low are not counted.
- R4: The best failing-check count restarts at all-ones at each leg start. A strictly lower `unsat_cnt_i` clears the stall counter, and an equal or higher count advances it. The result that brings the stall counter to `cfg_stall_win_i` ends the leg.
- R5: A `cfg_stall_win_i` of zero disables the stall abort.
- R6: A leg ends on its `cfg_max_iters_i`-th accepted result.
- R7: A result with `sat_i` high replaces the stored candidate only when no candidate is held or its `est_weight_i` is strictly lower. Ties keep the earlier candidate, and `best_weight_o` and `best_sol_o` show the stored one.
- R8: A satisfying result that leaves the decode's count of valid results below `cfg_sol_target_i` ends the current leg, and the next leg starts.
- R9: The satisfying result that brings the count of valid results to `cfg_sol_target_i` makes `done_o` rise on the next cycle, with `success_o` high.
- R10: When the leg numbered `cfg_max_legs_i` ends without reaching the target, the decode finishes. `success_o` is then high exactly when some valid candidate was stored.
- R11: `done_o` is high for one cycle. The reported values hold until the next decode starts, and `start_i` has no effect while a decode is in progress.
- R12: `iter_valid_i` has no effect while `run_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a decode (accepted when idle) |
| cfg_max_legs_i | input | LEG_W | Leg budget per decode (at least 1) |
| cfg_max_iters_i | input | IT_W | Iteration cap per leg (at least 1) |
| cfg_stall_win_i | input | WIN_W | Non-improving results that abort a leg; 0 disables |
| cfg_sol_target_i | input | LEG_W | Valid results needed to stop (at least 1) |
| weights_req_o | output | 1 | Leg-boundary pulse: redraw memory weights |
| core_init_o | output | 1 | Initialise core beliefs (first leg only) |
| run_o | output | 1 | Core may iterate |
| iter_valid_i | input | 1 | Core iteration result strobe |
| unsat_cnt_i | input | CNT_W | Failing checks after this iteration |
| sat_i | input | 1 | All checks satisfied |
| est_weight_i | input | WT_W | Error-estimate weight of the candidate |
| cand_i | input | N_BITS | Candidate error vector |
| done_o | output | 1 | One-cycle decode-finished pulse |
| success_o | output | 1 | A valid candidate is held |
| legs_used_o | output | LEG_W | Legs started in this decode |
| iters_total_o | output | TOT_W | Accepted iterations in this decode |
| best_weight_o | output | WT_W | Weight of the stored candidate |
| best_sol_o | output | N_BITS | Stored candidate vector |

## Verification
The assertions assume that the configuration inputs stay constant from `start_i` until `done_o`, and that the leg budget, the iteration cap and the solution target are all at least one. The per-leg bound on the iteration counter depends on that assumption. Every bench task sets the configuration while the block is idle and leaves it unchanged until the done pulse has been seen. The bench model of the core drives results only in cycles where it observed `run_o` high. The one task that pushes strobes and starts outside a leg checks that the block ignores them.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_RUN_LEG  = 2'd1,
      ST_NEXT_LEG = 2'd2,
      ST_DONE     = 2'd3
   } rlc_state_e;
endpackage

// File: rtl/rlc_stall_mon.sv
module rlc_stall_mon #(
   parameter int CNT_W = 8,
   parameter int WIN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             leg_start_i,
   input  logic             sample_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [WIN_W-1:0] window_i,
   output logic             stuck_o
);
   localparam logic [CNT_W-1:0] CNT_ONES = '1;
   localparam logic [WIN_W-1:0] WIN_ONES = '1;

   if (CNT_W < 2 || WIN_W < 1) begin : g_bad_w
      $error("rlc_stall_mon: CNT_W must be >= 2 and WIN_W >= 1");
   end

   logic [CNT_W-1:0] best_q;
   logic [WIN_W-1:0] stall_q;
   logic             improve;
   logic [WIN_W:0]   stall_nx;

   assign improve  = count_i < best_q;
   assign stall_nx = {1'b0, stall_q} + 1'b1;
   assign stuck_o  = sample_i && !improve && (window_i != '0)
                     && (stall_nx == {1'b0, window_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_q  <= CNT_ONES;
         stall_q <= '0;
      end else if (leg_start_i) begin
         best_q  <= CNT_ONES;
         stall_q <= '0;
      end else if (sample_i) begin
         if (improve) begin
            best_q  <= count_i;
            stall_q <= '0;
         end else if (stall_q != WIN_ONES) begin
            stall_q <= stall_q + 1'b1;
         end
      end
   end

   // R4: the best count within a leg never rises
   a_r4_best_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (!leg_start_i) |=> (best_q <= $past(best_q)));

   // R5: a zero window never reports a stall
   a_r5_zero_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (window_i == '0) |-> !stuck_o);
endmodule

// File: rtl/rlc_best_buf.sv
module rlc_best_buf #(
   parameter int N_BITS         = 16,
   parameter int WT_W           = 8,
   parameter bit TIE_KEEP_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              offer_i,
   input  logic [WT_W-1:0]   weight_i,
   input  logic [N_BITS-1:0] sol_i,
   output logic              valid_o,
   output logic [WT_W-1:0]   weight_o,
   output logic [N_BITS-1:0] sol_o
);
   if (N_BITS < 1 || WT_W < 1) begin : g_bad_w
      $error("rlc_best_buf: N_BITS and WT_W must be >= 1");
   end

   logic              valid_q;
   logic [WT_W-1:0]   weight_q;
   logic [N_BITS-1:0] sol_q;
   logic              better;

   if (TIE_KEEP_FIRST) begin : g_keep_first
      assign better = weight_i < weight_q;
   end else begin : g_keep_last
      assign better = weight_i <= weight_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         weight_q <= '0;
         sol_q    <= '0;
      end else if (clear_i) begin
         valid_q  <= 1'b0;
         weight_q <= '0;
         sol_q    <= '0;
      end else if (offer_i && (!valid_q || better)) begin
         valid_q  <= 1'b1;
         weight_q <= weight_i;
         sol_q    <= sol_i;
      end
   end

   assign valid_o  = valid_q;
   assign weight_o = weight_q;
   assign sol_o    = sol_q;

   // R7: a held candidate is only ever replaced by a lighter (or tied) one
   a_r7_weight_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !clear_i) |=> (valid_q && weight_q <= $past(weight_q)));
endmodule

// File: rtl/relay_leg_ctrl.sv
module relay_leg_ctrl
   import rlc_pkg::*;
#(
   parameter int N_BITS = 16,
   parameter int CNT_W  = 8,
   parameter int WT_W   = 8,
   parameter int LEG_W  = 4,
   parameter int IT_W   = 8,
   parameter int WIN_W  = 6,
   localparam int TOT_W = LEG_W + IT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LEG_W-1:0]  cfg_max_legs_i,
   input  logic [IT_W-1:0]   cfg_max_iters_i,
   input  logic [WIN_W-1:0]  cfg_stall_win_i,
   input  logic [LEG_W-1:0]  cfg_sol_target_i,
   output logic              weights_req_o,
   output logic              core_init_o,
   output logic              run_o,
   input  logic              iter_valid_i,
   input  logic [CNT_W-1:0]  unsat_cnt_i,
   input  logic              sat_i,
   input  logic [WT_W-1:0]   est_weight_i,
   input  logic [N_BITS-1:0] cand_i,
   output logic              done_o,
   output logic              success_o,
   output logic [LEG_W-1:0]  legs_used_o,
   output logic [TOT_W-1:0]  iters_total_o,
   output logic [WT_W-1:0]   best_weight_o,
   output logic [N_BITS-1:0] best_sol_o
);
   if (LEG_W < 1 || IT_W < 1) begin : g_bad_w
      $error("relay_leg_ctrl: LEG_W and IT_W must be >= 1");
   end

   rlc_state_e        state_q, state_d;
   logic [LEG_W-1:0]  legs_q;
   logic [LEG_W-1:0]  sols_q;
   logic [IT_W-1:0]   leg_iter_q;
   logic [TOT_W-1:0]  iters_q;
   logic              accept, launch, leg_open;
   logic              stuck, target_met, cap_hit, leg_end, last_leg;

   assign launch     = (state_q == ST_IDLE) && start_i;
   assign leg_open   = (state_q == ST_NEXT_LEG);
   assign run_o      = (state_q == ST_RUN_LEG);
   assign accept     = run_o && iter_valid_i;
   assign target_met = ({1'b0, sols_q} + 1'b1) >= {1'b0, cfg_sol_target_i};
   assign cap_hit    = ({1'b0, leg_iter_q} + 1'b1) >= {1'b0, cfg_max_iters_i};
   assign last_leg   = legs_q >= cfg_max_legs_i;
   assign leg_end    = accept && (sat_i || stuck || cap_hit);

   rlc_stall_mon #(.CNT_W(CNT_W), .WIN_W(WIN_W)) stall_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .leg_start_i(leg_open),
      .sample_i   (accept),
      .count_i    (unsat_cnt_i),
      .window_i   (cfg_stall_win_i),
      .stuck_o    (stuck)
   );

   rlc_best_buf #(.N_BITS(N_BITS), .WT_W(WT_W), .TIE_KEEP_FIRST(1'b1)) best_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (launch),
      .offer_i (accept && sat_i),
      .weight_i(est_weight_i),
      .sol_i   (cand_i),
      .valid_o (success_o),
      .weight_o(best_weight_o),
      .sol_o   (best_sol_o)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:     if (start_i) state_d = ST_NEXT_LEG;
         ST_NEXT_LEG: state_d = ST_RUN_LEG;
         ST_RUN_LEG: begin
            if (accept && sat_i && target_met) state_d = ST_DONE;
            else if (leg_end)                  state_d = last_leg ? ST_DONE : ST_NEXT_LEG;
         end
         ST_DONE:     state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         legs_q     <= '0;
         sols_q     <= '0;
         leg_iter_q <= '0;
         iters_q    <= '0;
      end else begin
         state_q <= state_d;
         if (launch) begin
            legs_q  <= '0;
            sols_q  <= '0;
            iters_q <= '0;
         end
         if (leg_open) begin
            legs_q     <= legs_q + 1'b1;
            leg_iter_q <= '0;
         end
         if (accept) begin
            leg_iter_q <= leg_iter_q + 1'b1;
            iters_q    <= iters_q + 1'b1;
            if (sat_i) sols_q <= sols_q + 1'b1;
         end
      end
   end

   assign weights_req_o = leg_open;
   assign core_init_o   = leg_open && (legs_q == '0);
   assign done_o        = (state_q == ST_DONE);
   assign legs_used_o   = legs_q;
   assign iters_total_o = iters_q;

   // R2: a leg-boundary request is always followed by a running leg
   a_r2_req_then_run: assert property (@(posedge clk) disable iff (!rst_n)
      weights_req_o |=> run_o);

   // R4: a detected stall closes the leg on the next cycle
   a_r4_stall_closes_leg: assert property (@(posedge clk) disable iff (!rst_n)
      stuck |=> (weights_req_o || done_o));

   // R6: the per-leg counter stays below the cap while a leg runs
   a_r6_leg_iter_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> (leg_iter_q < cfg_max_iters_i));

   // R9: reaching the target ends the decode with success
   a_r9_target_finishes: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && sat_i && target_met) |=> (done_o && success_o));

   // R11: done is a single-cycle pulse
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !run_o));

   // R12: the iteration total does not move outside a running leg
   a_r12_total_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_o && !launch) |=> $stable(iters_total_o));
endmodule

// File: tb/relay_leg_ctrl_tb_top.sv
`timescale 1ns/1ps
module relay_leg_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [3:0]  cfg_max_legs_i = 4'd1;
   logic [7:0]  cfg_max_iters_i = 8'd1;
   logic [5:0]  cfg_stall_win_i = 6'd0;
   logic [3:0]  cfg_sol_target_i = 4'd1;
   logic        weights_req_o, core_init_o, run_o;
   logic        iter_valid_i = 1'b0;
   logic [7:0]  unsat_cnt_i = '0;
   logic        sat_i = 1'b0;
   logic [7:0]  est_weight_i = '0;
   logic [15:0] cand_i = '0;
   logic        done_o, success_o;
   logic [3:0]  legs_used_o;
   logic [11:0] iters_total_o;
   logic [7:0]  best_weight_o;
   logic [15:0] best_sol_o;

   int n_tests = 0;
   int n_fail  = 0;
   int nreq, ninit, res_legs, res_iters, res_succ, res_wt, res_sol;
   int leg_iters [0:15];

   always #2 clk = ~clk;

   relay_leg_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cfg_max_legs_i(cfg_max_legs_i), .cfg_max_iters_i(cfg_max_iters_i),
      .cfg_stall_win_i(cfg_stall_win_i), .cfg_sol_target_i(cfg_sol_target_i),
      .weights_req_o(weights_req_o), .core_init_o(core_init_o), .run_o(run_o),
      .iter_valid_i(iter_valid_i), .unsat_cnt_i(unsat_cnt_i), .sat_i(sat_i),
      .est_weight_i(est_weight_i), .cand_i(cand_i), .done_o(done_o),
      .success_o(success_o), .legs_used_o(legs_used_o),
      .iters_total_o(iters_total_o), .best_weight_o(best_weight_o),
      .best_sol_o(best_sol_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Scripted core: result of iteration li in leg lg for scenario sc
   task automatic stim(input int sc, input int lg, input int li,
                       output logic [7:0] u, output logic s,
                       output logic [7:0] w, output logic [15:0] c);
      u = 8'd0; s = 1'b0; w = 8'd0; c = 16'h0;
      case (sc)
         2: u = (li == 0) ? 8'd10 : 8'd9;
         3: u = (li < 2) ? 8'd10 : (li < 4) ? 8'd9 : 8'd8;
         4: u = 8'd5;
         5: if (lg == 0) u = 8'd8;
            else if (li == 0) u = 8'd6;
            else if (li == 1) u = 8'd3;
            else begin s = 1'b1; w = 8'd7; c = 16'hA5A5; end
         6: if (lg == 0) begin
               if (li == 0) u = 8'd4; else begin s = 1'b1; w = 8'd9; c = 16'h0011; end
            end else if (lg == 1) begin
               s = 1'b1; w = 8'd5; c = 16'h0022;
            end else begin
               if (li == 0) u = 8'd3; else if (li == 1) u = 8'd2;
               else begin s = 1'b1; w = 8'd5; c = 16'h0033; end
            end
         7: if (lg == 0) begin s = 1'b1; w = 8'd4; c = 16'h0F0F; end
            else u = 8'd7;
         default: u = 8'd1;
      endcase
   endtask

   task automatic run_decode(input int sc, input bit hold_start);
      int  lg = -1;
      int  li = 0;
      int  guard = 0;
      bit  got = 0;
      bit  tgl = 0;
      nreq = 0; ninit = 0;
      for (int k = 0; k < 16; k++) leg_iters[k] = 0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); if (!hold_start) start_i = 1'b0;
      while (!got && guard < 5000) begin
         guard++;
         if (weights_req_o) begin
            nreq++;
            if (core_init_o) ninit++;
            if (run_o) chk("R2 run low during request", 1, 0);
            lg++; li = 0;
         end
         if (done_o) begin
            got = 1'b1; start_i = 1'b0;
            res_legs = legs_used_o; res_iters = iters_total_o;
            res_succ = success_o; res_wt = best_weight_o; res_sol = best_sol_o;
         end
         if (run_o && !(sc == 4 && tgl)) begin
            stim(sc, lg, li, unsat_cnt_i, sat_i, est_weight_i, cand_i);
            iter_valid_i = 1'b1;
            li++;
            if (lg >= 0 && lg < 16) leg_iters[lg]++;
         end else begin
            iter_valid_i = 1'b0; sat_i = 1'b0;
         end
         if (run_o) tgl = ~tgl;
         @(negedge clk);
      end
      iter_valid_i = 1'b0; sat_i = 1'b0;
      if (!got) chk("R10 decode finished", 0, 1);
   endtask

   task automatic cfg(input int legs, input int iters, input int win, input int tgt);
      cfg_max_legs_i = legs[3:0]; cfg_max_iters_i = iters[7:0];
      cfg_stall_win_i = win[5:0]; cfg_sol_target_i = tgt[3:0];
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 done", done_o, 0);
      chk("R1 run", run_o, 0);
      chk("R1 weights_req", weights_req_o, 0);
      chk("R1 core_init", core_init_o, 0);
      chk("R1 legs", legs_used_o, 0);
      chk("R1 iters", iters_total_o, 0);
      chk("R1 success", success_o, 0);
   endtask

   task automatic t_stall_basic();
      cfg(2, 20, 3, 1);
      run_decode(2, 0);
      chk("R4 leg0 iterations", leg_iters[0], 5);
      chk("R4 leg1 iterations", leg_iters[1], 5);
      chk("R2 weight requests", nreq, 2);
      chk("R2 init only first leg", ninit, 1);
      chk("R10 legs used", res_legs, 2);
      chk("R3 total iterations", res_iters, 10);
      chk("R10 no success", res_succ, 0);
   endtask

   task automatic t_stall_clear();
      cfg(1, 40, 2, 1);
      run_decode(3, 0);
      chk("R4 improvement clears stall", leg_iters[0], 7);
      chk("R4 total", res_iters, 7);
   endtask

   task automatic t_cap_gaps();
      cfg(3, 6, 0, 1);
      run_decode(4, 0);
      chk("R6 leg0 capped", leg_iters[0], 6);
      chk("R6 leg2 capped", leg_iters[2], 6);
      chk("R5 window zero: legs", res_legs, 3);
      chk("R3 gaps not counted", res_iters, 18);
      chk("R10 failure", res_succ, 0);
   endtask

   task automatic t_first_success();
      cfg(4, 20, 4, 1);
      run_decode(5, 0);
      chk("R9 legs", res_legs, 2);
      chk("R9 iterations", res_iters, 8);
      chk("R9 success", res_succ, 1);
      chk("R7 weight", res_wt, 7);
      chk("R7 solution", res_sol, 16'hA5A5);
   endtask

   task automatic t_multi_solution();
      cfg(5, 20, 4, 3);
      run_decode(6, 0);
      chk("R8 leg0 ended by solution", leg_iters[0], 2);
      chk("R8 leg1 ended by solution", leg_iters[1], 1);
      chk("R9 legs at target", res_legs, 3);
      chk("R3 iterations", res_iters, 6);
      chk("R7 lowest weight", res_wt, 5);
      chk("R7 tie keeps earlier", res_sol, 16'h0022);
      chk("R9 success", res_succ, 1);
   endtask

   task automatic t_budget_with_solution();
      cfg(2, 3, 0, 2);
      run_decode(7, 0);
      chk("R10 legs", res_legs, 2);
      chk("R10 iterations", res_iters, 4);
      chk("R10 success with stored candidate", res_succ, 1);
      chk("R10 stored weight", res_wt, 4);
      chk("R10 stored solution", res_sol, 16'h0F0F);
   endtask

   task automatic t_ignored();
      bit seen = 0;
      iter_valid_i = 1'b1; sat_i = 1'b1; est_weight_i = 8'd1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (run_o || done_o || weights_req_o) seen = 1'b1;
      end
      iter_valid_i = 1'b0; sat_i = 1'b0;
      chk("R12 idle strobes ignored", seen, 0);
      chk("R12 total unchanged", iters_total_o, 4);
      cfg(1, 20, 3, 1);
      run_decode(2, 1);
      chk("R11 held start: requests", nreq, 1);
      chk("R11 held start: iterations", res_iters, 5);
      chk("R11 done width", done_o, 0);
      repeat (3) @(negedge clk);
      chk("R11 legs held", legs_used_o, 1);
      chk("R11 iterations held", iters_total_o, 5);
      chk("R11 no restart", run_o | weights_req_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_stall_basic();
      t_stall_clear();
      t_cap_gaps();
      t_first_success();
      t_multi_solution();
      t_budget_with_solution();
      t_ignored();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule